// File: doc/BRIEF.md
# Charge Hold Shock Sequencer

This block is the phase controller for one capacitor-discharge therapy cycle. From idle, a debounced press of the charge key starts the charge phase. When the charge-complete comparator reports a full capacitor, the block moves to the hold (ready) phase. A debounced shock key then delivers the shock, and the block returns to idle. In every phase it drives a fixed set of enables: high-voltage generator enable, dump relay drive, charge load, patient-discharge enable, patient relay and ready indicator. It also drives a SYNC level that reports whether synchronised mode is selected.

All timing comes from a single-cycle `tick_i` strobe, so every duration is a count of ticks set by a parameter. With the default 10 ms tick these are:
- a 20 s cap on the hold phase;
- a 100 ms patient relay pulse;
- a 30 ms key debounce.

A separate battery-test request powers the generator without engaging the dump relay.

A fault-latch status or an out-of-range impedance flag aborts charge or hold. Either one also blocks the shock.

Top module: `therapy_seq`

## Requirements
- R1: The key inputs are active low (0 = pressed). They pass through two synchroniser flops, and a new key level is accepted only after it has differed from the accepted level on DEB_TICKS consecutive ticks. A level that lasts for a single tick is ignored.
- R2: In idle with no fault, an accepted charge-key press enters charge: `gen_en_o`, `dump_o` and `load_o` go high, and `pdu_en_o`, `ready_o` and `relay_o` stay low.
- R3: `load_o` is high only in charge. It drops on the cycle that `chg_done_i` moves the block into hold, and it never falls while the dump relay stays up outside hold.
- R4: In hold, `gen_en_o`, `dump_o`, `pdu_en_o` and `ready_o` are high, and `load_o` and `relay_o` are low.
- R5: Hold lasts at most HOLD_TICKS ticks. On expiry, `ready_o` and `pdu_en_o` fall, and `dump_o` stays high for exactly one more tick with `gen_en_o` low. All outputs are then low.
- R6: In direct mode (`sync_mode_i` = 0), an accepted shock-key press in hold enters shock. In shock, `relay_o` is high for exactly PULSE_TICKS ticks while `ready_o` is low, and then every output goes low. Shock is entered only from hold.
- R7: In synchronised mode (`sync_mode_i` = 1), a held shock key fires only while the synchronised `qrs_n_i` is low (0 = QRS in progress). `sync_o` follows `sync_mode_i` one clock later: 0 means direct, 1 means synchronised.
- R8: `fault_i` = 1 or `imp_ok_i` = 0 in charge or hold returns the block to idle with all outputs low. The shock is never entered while either condition is present, and a charge does not start while `fault_i` is high.
- R9: `btest_req_i` = 1 in idle raises `gen_en_o` alone, with `dump_o` low. The block returns to idle when the request drops.
- R10: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| tick_i | input | 1 | one-cycle timing strobe |
| chg_key_n_i | input | 1 | charge key, active low |
| shk_key_n_i | input | 1 | shock key, active low |
| chg_done_i | input | 1 | capacitor charged flag |
| imp_ok_i | input | 1 | patient impedance in range |
| qrs_n_i | input | 1 | QRS trigger, active low |
| sync_mode_i | input | 1 | 1 = synchronised mode |
| fault_i | input | 1 | fault latch tripped |
| btest_req_i | input | 1 | battery test request |
| gen_en_o | output | 1 | high-voltage generator enable |
| dump_o | output | 1 | dump relay drive |
| load_o | output | 1 | charge load |
| pdu_en_o | output | 1 | patient-discharge enable |
| relay_o | output | 1 | patient relay pulse |
| ready_o | output | 1 | ready indicator |
| sync_o | output | 1 | synchronised-mode level |

## Verification
The assertions check, on every cycle, these relations:
- charge load always implies dump;
- shock is entered only from hold, never under a fault or a bad impedance, and in synchronised mode only with QRS low;
- the accepted key level changes only on a tick;
- the phase counters never run past their limits.

The exact length of the hold window, the single extra tick of dump after a timeout, the relay pulse width and the rejection of a one-tick key glitch depend on tick counts. Only the bench scenarios show these.

// File: rtl/therapy_pkg.sv
// Package for the therapy sequencer: phase encoding shared by the controller.
// Assumes nothing beyond a single clock domain.
package therapy_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CHARGE = 3'd1,
        PH_HOLD   = 3'd2,
        PH_SHOCK  = 3'd3,
        PH_DUMP   = 3'd4,
        PH_BTEST  = 3'd5
    } phase_t;

    localparam int unsigned NUM_KEYS = 2;
    localparam int unsigned KEY_CHG  = 0;
    localparam int unsigned KEY_SHK  = 1;

endpackage

// File: rtl/key_filter.sv
// Key conditioner: two-flop synchroniser followed by a tick-based debounce.
// Assumes an active-low raw key and a one-cycle tick strobe; pressed_o is active high.
module key_filter #(
    parameter int unsigned DEB_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_n_i,
    output logic pressed_o
);
    localparam int unsigned CW = $clog2(DEB_TICKS + 1);

    logic [1:0]    sync_q;
    logic          stable_q;
    logic [CW-1:0] cnt_q;

    // Bring the raw key into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_n_i};
    end

    // Accept a new level after DEB_TICKS consecutive differing ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b1;
            cnt_q    <= '0;
        end else if (sync_q[1] == stable_q) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == CW'(DEB_TICKS - 1)) begin
                stable_q <= sync_q[1];
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pressed_o = ~stable_q;

    // R1
    stable_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stable_q != $past(stable_q)) |-> ($past(tick_i) && stable_q == $past(sync_q[1])));

    // R1
    deb_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(DEB_TICKS));
endmodule

// File: rtl/phase_timer.sv
// Phase timer: counts ticks since the last clear and flags the LIMIT-th tick.
// Assumes clear_i is raised on every phase change; done_o is combinational.
module phase_timer #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign done_o = tick_i && (cnt_q == CW'(LIMIT - 1));

    // Count ticks, restarting on clear or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (done_o)       cnt_q <= '0;
        else if (tick_i)       cnt_q <= cnt_q + 1'b1;
    end

    // R5
    tmr_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
endmodule

// File: rtl/therapy_seq.sv
// Therapy sequencer top: idle -> charge -> hold -> shock -> idle, with a hold
// timeout dump tail, fault/impedance abort, synchronised-shock gating and a
// battery test phase. Assumes a one-cycle tick_i strobe and a synchronous
// active-low reset. Outputs are decoded from the registered phase.
module therapy_seq
    import therapy_pkg::*;
#(
    parameter int unsigned DEB_TICKS   = 3,
    parameter int unsigned HOLD_TICKS  = 2000,
    parameter int unsigned PULSE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic chg_key_n_i,
    input  logic shk_key_n_i,
    input  logic chg_done_i,
    input  logic imp_ok_i,
    input  logic qrs_n_i,
    input  logic sync_mode_i,
    input  logic fault_i,
    input  logic btest_req_i,
    output logic gen_en_o,
    output logic dump_o,
    output logic load_o,
    output logic pdu_en_o,
    output logic relay_o,
    output logic ready_o,
    output logic sync_o
);
    logic [NUM_KEYS-1:0] raw_n, pressed;
    logic [1:0]          qrs_q;
    logic                qrs_act;
    logic                sync_q;
    logic                abort, fire;
    logic                hold_done, pulse_done, phase_chg;
    phase_t              state_q, state_d;

    assign raw_n[KEY_CHG] = chg_key_n_i;
    assign raw_n[KEY_SHK] = shk_key_n_i;

    // One conditioner per key.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        key_filter #(.DEB_TICKS(DEB_TICKS)) u_key (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .raw_n_i  (raw_n[k]),
            .pressed_o(pressed[k])
        );
    end

    // Synchronise the QRS trigger and register the mode level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qrs_q  <= 2'b11;
            sync_q <= 1'b0;
        end else begin
            qrs_q  <= {qrs_q[0], qrs_n_i};
            sync_q <= sync_mode_i;
        end
    end

    assign qrs_act = ~qrs_q[1];
    assign abort   = fault_i || !imp_ok_i;
    assign fire    = pressed[KEY_SHK] && (!sync_mode_i || qrs_act);

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PH_IDLE: begin
                if (pressed[KEY_CHG] && !fault_i) state_d = PH_CHARGE;
                else if (btest_req_i)             state_d = PH_BTEST;
            end
            PH_CHARGE: begin
                if (abort)           state_d = PH_IDLE;
                else if (chg_done_i) state_d = PH_HOLD;
            end
            PH_HOLD: begin
                if (abort)          state_d = PH_IDLE;
                else if (hold_done) state_d = PH_DUMP;
                else if (fire)      state_d = PH_SHOCK;
            end
            PH_SHOCK: if (pulse_done) state_d = PH_IDLE;
            PH_DUMP:  if (tick_i)     state_d = PH_IDLE;
            PH_BTEST: if (!btest_req_i) state_d = PH_IDLE;
            default:  state_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    assign phase_chg = (state_q != state_d);

    phase_timer #(.LIMIT(HOLD_TICKS)) u_hold_tmr (
        .clk(clk), .rst_n(rst_n), .clear_i(phase_chg || state_q != PH_HOLD),
        .tick_i(tick_i), .done_o(hold_done)
    );

    phase_timer #(.LIMIT(PULSE_TICKS)) u_pulse_tmr (
        .clk(clk), .rst_n(rst_n), .clear_i(phase_chg || state_q != PH_SHOCK),
        .tick_i(tick_i), .done_o(pulse_done)
    );

    // Per-phase output pattern.
    always_comb begin
        gen_en_o = state_q inside {PH_CHARGE, PH_HOLD, PH_SHOCK, PH_BTEST};
        dump_o   = state_q inside {PH_CHARGE, PH_HOLD, PH_SHOCK, PH_DUMP};
        load_o   = (state_q == PH_CHARGE);
        pdu_en_o = (state_q == PH_HOLD);
        ready_o  = (state_q == PH_HOLD);
        relay_o  = (state_q == PH_SHOCK);
    end

    assign sync_o = sync_q;

    // R3
    load_needs_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (dump_o && gen_en_o && !ready_o));

    // R3
    load_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_o) |-> (ready_o || !dump_o));

    // R6
    shock_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relay_o) |-> $past(ready_o));

    // R8
    shock_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relay_o) |-> ($past(!fault_i) && $past(imp_ok_i)));

    // R7
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(relay_o) && $past(sync_mode_i)) |-> $past(qrs_act));

    // R9
    btest_no_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en_o && !dump_o) |-> (!ready_o && !relay_o && !load_o));
endmodule

// File: tb/tb_therapy_seq.sv
module tb_therapy_seq;
    localparam int DEB = 2;
    localparam int HOLD = 40;
    localparam int PULSE = 3;
    localparam int NVEC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic ck_n = 1'b1, sk_n = 1'b1, cdone = 1'b0, imp = 1'b1, qrs_n = 1'b1;
    logic smode = 1'b0, flt = 1'b0, bt = 1'b0;
    logic gen_en, dump, load, pdu_en, relay, ready, sync_lvl;
    logic [1:0] tcnt = '0;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    // Tick every fourth cycle.
    always @(posedge clk) begin
        tcnt <= tcnt + 1'b1;
        tick <= (tcnt == 2'd3);
    end

    therapy_seq #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .PULSE_TICKS(PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .chg_key_n_i(ck_n), .shk_key_n_i(sk_n), .chg_done_i(cdone),
        .imp_ok_i(imp), .qrs_n_i(qrs_n), .sync_mode_i(smode),
        .fault_i(flt), .btest_req_i(bt),
        .gen_en_o(gen_en), .dump_o(dump), .load_o(load), .pdu_en_o(pdu_en),
        .relay_o(relay), .ready_o(ready), .sync_o(sync_lvl)
    );

    // {ck_n,sk_n,cdone,imp,qrs_n,smode,flt,bt, exp gen,dump,load,pdu,ready,relay}
    localparam logic [13:0] VEC [NVEC] = '{
        14'b11011000_000000,  // R10 idle
        14'b01011000_111000,  // R2 charge
        14'b11011000_111000,  // R3 charge holds without key
        14'b11111000_110110,  // R4 hold
        14'b10011000_000000,  // R6 direct shock done
        14'b11011000_000000,
        14'b01011100_111000,  // R2 charge, sync mode
        14'b11111100_110110,  // R4 hold
        14'b10011100_110110,  // R7 no QRS, no shock
        14'b10010100_000000,  // R7 QRS fires shock
        14'b11011100_000000,
        14'b01011000_111000,  // R2
        14'b11011010_000000,  // R8 fault aborts charge
        14'b11011000_000000,
        14'b01011000_111000,  // R2
        14'b11111000_110110,  // R4
        14'b11001000_000000,  // R8 impedance aborts hold
        14'b11011000_000000,
        14'b11011001_100000,  // R9 battery test
        14'b11011000_000000   // R9 end
    };

    function automatic logic [5:0] outs();
        return {gen_en, dump, load, pdu_en, ready, relay};
    endfunction

    task automatic check(input bit ok, input string req, input logic [5:0] act,
                         input logic [5:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (4 * n) @(posedge clk);
        @(negedge clk);
    endtask

    // Count ticks seen while cond holds; cond selected by sel.
    task automatic count_while(input int sel, output int cnt);
        cnt = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sel == 0 && !ready) break;
            if (sel == 1 && !dump) break;
            if (sel == 2 && !relay) break;
            if (tick) cnt++;
        end
    endtask

    initial begin
        int c;
        logic [5:0] e;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(outs() == 6'b0 && sync_lvl == 1'b0, "R10", outs(), 6'b0);
        rst_n = 1'b1;
        wait_ticks(2);

        for (int i = 0; i < NVEC; i++) begin
            {ck_n, sk_n, cdone, imp, qrs_n, smode, flt, bt} = VEC[i][13:6];
            wait_ticks(6);
            e = VEC[i][5:0];
            check(outs() == e, $sformatf("vector %0d R2-set", i), outs(), e);
            // R7 sync level follows mode
            check(sync_lvl == smode, "R7 sync", {5'b0, sync_lvl}, {5'b0, smode});
        end

        // R1 one-tick glitch on charge key is ignored
        @(negedge clk); ck_n = 1'b0;
        repeat (4) @(negedge clk);
        ck_n = 1'b1;
        wait_ticks(6);
        check(outs() == 6'b0, "R1 glitch", outs(), 6'b0);

        // R5 hold timeout and dump tail
        ck_n = 1'b0; wait_ticks(5); ck_n = 1'b1; cdone = 1'b1;
        for (int i = 0; i < 20 && !ready; i++) @(negedge clk);
        check(ready == 1'b1, "R4 hold entry", outs(), 6'b110110);
        count_while(0, c);
        check(c == HOLD, "R5 hold ticks", 6'(c), 6'(HOLD));
        check(dump && !gen_en && !pdu_en, "R5 tail state", outs(), 6'b010000);
        count_while(1, c);
        check(c == 1, "R5 tail ticks", 6'(c), 6'd1);
        cdone = 1'b0;
        wait_ticks(2);
        check(outs() == 6'b0, "R5 idle after tail", outs(), 6'b0);

        // R6 relay pulse width
        ck_n = 1'b0; wait_ticks(5); ck_n = 1'b1; cdone = 1'b1;
        wait_ticks(2); cdone = 1'b0;
        sk_n = 1'b0;
        for (int i = 0; i < 40 && !relay; i++) @(negedge clk);
        check(relay && !ready && dump, "R6 shock state", outs(), 6'b110001);
        count_while(2, c);
        check(c == PULSE, "R6 pulse ticks", 6'(c), 6'(PULSE));
        check(outs() == 6'b0, "R6 idle after shock", outs(), 6'b0);
        sk_n = 1'b1;
        wait_ticks(4);

        // R8 fault blocks charge start
        flt = 1'b1; ck_n = 1'b0; wait_ticks(6);
        check(outs() == 6'b0, "R8 no charge under fault", outs(), 6'b0);
        ck_n = 1'b1; wait_ticks(4); flt = 1'b0;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule